// File: doc/BRIEF.md
# Sampled Phase-Frequency Detector with Hysteretic Lock Indicator

This block compares two pulse trains, one from a reference divider and one from a feedback divider, and turns the timing difference between their rising edges into pump-up and pump-down requests. It works as a three-state phase-frequency detector: the first edge to arrive raises its own request, the second edge raises the other, and once both are raised a short reset delay keeps them overlapping for a fixed number of cycles before both are cleared together. That enforced overlap removes the dead zone around zero phase error.

Everything runs on a fast sampling clock, so the phase error of each detector cycle is simply the number of clock cycles in which exactly one request is raised. Each completed cycle is graded against two count thresholds. A run of consecutive small-error cycles sets an active-high lock flag, and a single large-error cycle clears it. A polarity input exchanges the two requests for loops whose oscillator tunes the other way, and a three-state input silences both requests and forces the lock flag low.

Top module: `pfd_lock_detect`

## Requirements
- R1: A rising edge on `ref_pulse` or `div_pulse` raises that input's internal request one clock later; the request that rises first stays raised for d + RST_DLY cycles, where d is the edge spacing in clock cycles.
- R2: Once both requests are raised they overlap for exactly RST_DLY cycles (default 2) and are then cleared in the same cycle; when both edges coincide each is raised for RST_DLY cycles.
- R3: With `polarity` = 1, `up` shows the reference-side request and `down` the feedback-side request; with `polarity` = 0 the two are exchanged.
- R4: While `three_state` = 1, `up` and `down` are both 0.
- R5: The error of a detector cycle is the count of cycles in which exactly one request is raised; a cycle with error below ENTER_TH (default 15) counts as good, and `lock` rises when LOCK_RUN (default 3) consecutive cycles are good.
- R6: A cycle whose error exceeds EXIT_TH (default 25) drives `lock` low and clears the run of good cycles.
- R7: A cycle whose error lies from ENTER_TH to EXIT_TH inclusive leaves `lock` unchanged but clears the run of good cycles.
- R8: While `three_state` = 1, `lock` is 0 and the run of good cycles is cleared, so after release LOCK_RUN fresh good cycles are needed.
- R9: While `rst_n` = 0, `up`, `down` and `lock` are all 0, including when a request was raised before reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_pulse | input | 1 | Reference-divider pulse, synchronous to clk |
| div_pulse | input | 1 | Feedback-divider pulse, synchronous to clk |
| polarity | input | 1 | 1: normal sense, 0: up and down exchanged |
| three_state | input | 1 | 1: both requests off, lock held low |
| up | output | 1 | Pump-up request |
| down | output | 1 | Pump-down request |
| lock | output | 1 | Digital lock flag, active high |

## Verification
The detector is driven with edge pairs whose spacing and order vary: coincident edges, small leads of either input, and spacings placed one count on each side of both thresholds (14 and 15 against entry, 25 and 26 against exit). Counting the cycles each output is high separates the leading-side width d + RST_DLY from the fixed overlap, and running each pattern under both polarity values shows the exchange. The lock sequence is ordered so that a mid-band error interrupts a run of good cycles, proving the run is cleared while lock holds, and a three-state interval followed by single good cycles shows the run had been cleared there too.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_REGD = 1'b1
   } out_mode_e;

   function automatic int width_for(input int max_value);
      int w;
      w = 1;
      while ((1 << w) <= max_value) w++;
      return w;
   endfunction

endpackage

// File: rtl/pfd_edge_core.sv
module pfd_edge_core #(
   parameter int RST_DLY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_pulse,
   input  logic div_pulse,
   output logic ref_flag,
   output logic div_flag,
   output logic cycle_done
);
   import pfd_lock_pkg::*;

   localparam int DW = width_for(RST_DLY);
   localparam logic [DW-1:0] LAST = DW'(RST_DLY - 1);

   logic          ref_q;
   logic          div_q;
   logic          both;
   logic [DW-1:0] dly_cnt;

   assign both       = ref_flag & div_flag;
   assign cycle_done = both && (dly_cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q    <= 1'b0;
         div_q    <= 1'b0;
         ref_flag <= 1'b0;
         div_flag <= 1'b0;
         dly_cnt  <= '0;
      end else begin
         ref_q <= ref_pulse;
         div_q <= div_pulse;
         if (cycle_done) begin
            ref_flag <= 1'b0;
            div_flag <= 1'b0;
         end else begin
            ref_flag <= ref_flag | (ref_pulse & ~ref_q);
            div_flag <= div_flag | (div_pulse & ~div_q);
         end
         if (!both || cycle_done) dly_cnt <= '0;
         else                     dly_cnt <= dly_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/pfd_err_meter.sv
module pfd_err_meter #(
   parameter int ERR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_flag,
   input  logic             div_flag,
   input  logic             cycle_done,
   output logic [ERR_W-1:0] err_val
);

   localparam logic [ERR_W-1:0] ERR_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_val <= '0;
      end else if (cycle_done) begin
         err_val <= '0;
      end else if ((ref_flag ^ div_flag) && (err_val != ERR_MAX)) begin
         err_val <= err_val + 1'b1;
      end
   end

endmodule

// File: rtl/pfd_lock_fsm.sv
module pfd_lock_fsm #(
   parameter int ERR_W    = 8,
   parameter int ENTER_TH = 15,
   parameter int EXIT_TH  = 25,
   parameter int LOCK_RUN = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             cycle_done,
   input  logic [ERR_W-1:0] err_val,
   output logic             lock
);
   import pfd_lock_pkg::*;

   localparam int GW = width_for(LOCK_RUN);
   localparam logic [GW-1:0]    RUN_V   = GW'(LOCK_RUN);
   localparam logic [ERR_W-1:0] ENTER_V = ERR_W'(ENTER_TH);
   localparam logic [ERR_W-1:0] EXIT_V  = ERR_W'(EXIT_TH);

   logic [GW-1:0] good_cnt;
   logic [GW-1:0] good_nxt;
   logic          is_good;
   logic          is_bad;

   assign is_good  = err_val < ENTER_V;
   assign is_bad   = err_val > EXIT_V;
   assign good_nxt = (good_cnt == RUN_V) ? good_cnt : good_cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock     <= 1'b0;
         good_cnt <= '0;
      end else if (hold) begin
         lock     <= 1'b0;
         good_cnt <= '0;
      end else if (cycle_done) begin
         if (is_good) begin
            good_cnt <= good_nxt;
            if (good_nxt == RUN_V) lock <= 1'b1;
         end else if (is_bad) begin
            lock     <= 1'b0;
            good_cnt <= '0;
         end else begin
            good_cnt <= '0;
         end
      end
   end

endmodule

// File: rtl/pfd_lock_detect.sv
module pfd_lock_detect #(
   parameter int                      RST_DLY  = 2,
   parameter int                      ERR_W    = 8,
   parameter int                      ENTER_TH = 15,
   parameter int                      EXIT_TH  = 25,
   parameter int                      LOCK_RUN = 3,
   parameter pfd_lock_pkg::out_mode_e OUT_MODE = pfd_lock_pkg::OUT_COMB
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_pulse,
   input  logic div_pulse,
   input  logic polarity,
   input  logic three_state,
   output logic up,
   output logic down,
   output logic lock
);
   import pfd_lock_pkg::*;

   generate
      if (RST_DLY < 1) begin : g_bad_dly
         $error("RST_DLY must be at least 1");
      end
      if (LOCK_RUN < 1) begin : g_bad_run
         $error("LOCK_RUN must be at least 1");
      end
      if (ENTER_TH > EXIT_TH) begin : g_bad_th
         $error("ENTER_TH must not exceed EXIT_TH");
      end
      if (EXIT_TH >= (1 << ERR_W) - 1) begin : g_bad_w
         $error("ERR_W too narrow for EXIT_TH");
      end
   endgenerate

   logic             ref_flag;
   logic             div_flag;
   logic             cycle_done;
   logic [ERR_W-1:0] err_val;
   logic             up_raw;
   logic             dn_raw;
   logic             up_sel;
   logic             dn_sel;

   pfd_edge_core #(.RST_DLY(RST_DLY)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_pulse  (ref_pulse),
      .div_pulse  (div_pulse),
      .ref_flag   (ref_flag),
      .div_flag   (div_flag),
      .cycle_done (cycle_done)
   );

   pfd_err_meter #(.ERR_W(ERR_W)) u_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_flag   (ref_flag),
      .div_flag   (div_flag),
      .cycle_done (cycle_done),
      .err_val    (err_val)
   );

   pfd_lock_fsm #(
      .ERR_W    (ERR_W),
      .ENTER_TH (ENTER_TH),
      .EXIT_TH  (EXIT_TH),
      .LOCK_RUN (LOCK_RUN)
   ) u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold       (three_state),
      .cycle_done (cycle_done),
      .err_val    (err_val),
      .lock       (lock)
   );

   assign up_raw = polarity ? ref_flag : div_flag;
   assign dn_raw = polarity ? div_flag : ref_flag;

   generate
      if (OUT_MODE == OUT_REGD) begin : g_out_regd
         logic up_q;
         logic dn_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               up_q <= 1'b0;
               dn_q <= 1'b0;
            end else begin
               up_q <= up_raw;
               dn_q <= dn_raw;
            end
         end
         assign up_sel = up_q;
         assign dn_sel = dn_q;
      end else begin : g_out_comb
         assign up_sel = up_raw;
         assign dn_sel = dn_raw;
      end
   endgenerate

   assign up   = up_sel & ~three_state;
   assign down = dn_sel & ~three_state;

endmodule

// File: rtl/pfd_lock_detect_chk.sv
module pfd_lock_detect_chk #(
   parameter int RST_DLY  = 2,
   parameter int ERR_W    = 8,
   parameter int ENTER_TH = 15,
   parameter int EXIT_TH  = 25
) (
   input logic             clk,
   input logic             rst_n,
   input logic             three_state,
   input logic             up,
   input logic             down,
   input logic             lock,
   input logic             cycle_done,
   input logic [ERR_W-1:0] err_val
);

   localparam logic [ERR_W-1:0] ENTER_V = ERR_W'(ENTER_TH);
   localparam logic [ERR_W-1:0] EXIT_V  = ERR_W'(EXIT_TH);

   int ov_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             ov_run <= 0;
      else if (up && down)    ov_run <= (ov_run < 1000) ? ov_run + 1 : ov_run;
      else                    ov_run <= 0;
   end

   // R2: overlap never lasts longer than the reset delay
   p_overlap_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (up && down) |-> (ov_run < RST_DLY));

   p_quiet_tristate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      three_state |-> (!up && !down));

   p_lock_from_good_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock) |-> $past(cycle_done && (err_val < ENTER_V) && !three_state));

   p_exit_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_done && (err_val > EXIT_V)) |=> !lock);

   p_mid_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_done && !three_state && (err_val >= ENTER_V) && (err_val <= EXIT_V))
      |=> (lock == $past(lock)));

   p_tristate_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      three_state |=> !lock);

endmodule

bind pfd_lock_detect pfd_lock_detect_chk #(
   .RST_DLY  (RST_DLY),
   .ERR_W    (ERR_W),
   .ENTER_TH (ENTER_TH),
   .EXIT_TH  (EXIT_TH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .three_state (three_state),
   .up          (up),
   .down        (down),
   .lock        (lock),
   .cycle_done  (cycle_done),
   .err_val     (err_val)
);

// File: tb/pfd_lock_detect_test.sv
module pfd_lock_detect_test;

   localparam int CLK_PERIOD = 10;
   localparam int DLY        = 2;
   localparam int NV         = 14;

   // spacing, reference leads, polarity, expected lock after the cycle
   localparam int VD    [NV] = '{3, 0, 5, 20, 14, 25, 26, 15, 2, 2, 20, 1, 1, 1};
   localparam int VREF  [NV] = '{1, 1, 0, 1,  1,  0,  1,  1, 1, 0, 1,  0, 1, 1};
   localparam int VPOL  [NV] = '{1, 1, 1, 1,  1,  1,  1,  1, 0, 0, 0,  1, 0, 1};
   localparam int VLOCK [NV] = '{0, 0, 1, 1,  1,  1,  0,  0, 0, 0, 0,  0, 0, 1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_pulse = 1'b0;
   logic div_pulse = 1'b0;
   logic polarity = 1'b1;
   logic three_state = 1'b0;
   logic up, down, lock;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pfd_lock_detect uut (
      .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .div_pulse(div_pulse),
      .polarity(polarity), .three_state(three_state),
      .up(up), .down(down), .lock(lock)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_det(input int d, input bit ref_first, input bit pol,
                          output int up_n, output int dn_n);
      up_n = 0;
      dn_n = 0;
      @(negedge clk);
      polarity = pol;
      for (int i = 0; i <= d + DLY + 4; i++) begin
         @(negedge clk);
         if (up)   up_n++;
         if (down) dn_n++;
         ref_pulse = ref_first ? (i == 0) : (i == d);
         div_pulse = ref_first ? (i == d) : (i == 0);
      end
      ref_pulse = 1'b0;
      div_pulse = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int un, dn, ref_w, div_w;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 up in reset", int'(up), 0);
      chk("R9 down in reset", int'(down), 0);
      chk("R9 lock in reset", int'(lock), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R2 R3 R5 R6 R7: table walk
      for (int v = 0; v < NV; v++) begin
         run_det(VD[v], VREF[v][0], VPOL[v][0], un, dn);
         ref_w = VREF[v] != 0 ? VD[v] + DLY : DLY;
         div_w = VREF[v] != 0 ? DLY : VD[v] + DLY;
         chk($sformatf("R1/R3 up width vec %0d", v), un, VPOL[v] != 0 ? ref_w : div_w);
         chk($sformatf("R2/R3 down width vec %0d", v), dn, VPOL[v] != 0 ? div_w : ref_w);
         chk($sformatf("R5/R6/R7 lock vec %0d", v), int'(lock), VLOCK[v]);
      end

      // R4 R8: three-state silences outputs and drops lock
      three_state = 1'b1;
      run_det(4, 1'b1, 1'b1, un, dn);
      chk("R4 up count in three-state", un, 0);
      chk("R4 down count in three-state", dn, 0);
      chk("R8 lock in three-state", int'(lock), 0);
      three_state = 1'b0;
      run_det(1, 1'b1, 1'b1, un, dn);
      chk("R8 run cleared, lock after 1 good", int'(lock), 0);
      run_det(1, 1'b0, 1'b1, un, dn);
      chk("R8 run cleared, lock after 2 good", int'(lock), 0);
      run_det(1, 1'b1, 1'b1, un, dn);
      chk("R5 lock after 3 good", int'(lock), 1);

      // R9: reset while a request is raised
      @(negedge clk);
      ref_pulse = 1'b1;
      @(negedge clk);
      ref_pulse = 1'b0;
      @(negedge clk);
      chk("R1 request raised before reset", int'(up), 1);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R9 up cleared by reset", int'(up), 0);
      chk("R9 lock cleared by reset", int'(lock), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R9 up stays low after reset", int'(up), 0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule